// File: doc/BRIEF.md
# Tracking Servo Brake and Mask Control

This block sits in front of and behind the tracking servo filter of an optical disc servo. It chooses which error sample feeds the filter, either the tracking error or the centre error, and it can zero that sample. On the output side it can zero the filter result, or freeze it, before it reaches the actuator drive. The filter arithmetic is outside the block. The filter's result is routed back through the block, and the block hands the conditioned value on.

Braking uses a cancel flag. The block resynchronises the mirror level and the track-zero-cross level. On every change of the zero-cross level, in either direction, it stores the current mirror level as the cancel flag. A control bit chooses whether the cancel flag zeroes the filter input or the filter output. A separate mirror-mask bit zeroes the filter input whenever the mirror level is high.

Around a surf jump, the output can be frozen at the last value it held before the jump began. A one-clock request to zero the filter state memory can also be issued when the block returns from the jump to servo-on.

Top module: `trk_brake_ctrl`

## Requirements
- R1: `mirr_in` and `tzc_in` each pass through a two-flop synchroniser. Every change of the synchronised zero-cross level, rising or falling, loads the synchronised mirror level into the cancel flag on the next clock. With no zero-cross change the flag keeps its value, whatever the mirror level does.
- R2: With `cfg_brake_at_input` = 0 and no hold active, `trk_drive` takes `filt_dout` one clock later. It takes zero instead while the cancel flag is 1.
- R3: With `cfg_brake_at_input` = 1, `filt_din` is zero one clock after any cycle in which the cancel flag is 1. In that case `trk_drive` is not masked by the cancel flag.
- R4: With `cfg_mirr_mask` = 1, `filt_din` is zero one clock after any cycle in which the synchronised mirror level is 1, whatever the cancel flag holds.
- R5: While `cfg_hold_surf`, `surf_jump` and `jump_active` are all 1, `trk_drive` keeps the value it held before the hold began. Hold takes precedence over output masking. When the hold ends, `trk_drive` follows R2 again.
- R6: `filt_clear` is high for exactly one clock. It rises one clock after a cycle in which `jump_active` has gone from 1 to 0 while `surf_jump` = 1 and `cfg_clear_on_servo` = 1. It never rises otherwise.
- R7: When not masked, `filt_din` is `ce_in` when `cfg_swap_ce` = 1 and `te_in` when it is 0, registered with one clock of latency.
- R8: During and right after reset, `filt_din`, `trk_drive` and `filt_clear` are zero and the cancel flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| te_in | input | SAMPLE_W | Tracking error sample |
| ce_in | input | SAMPLE_W | Centre error sample |
| mirr_in | input | 1 | Mirror level, asynchronous |
| tzc_in | input | 1 | Track-zero-cross level, asynchronous |
| jump_active | input | 1 | 1 = track jump in progress, 0 = servo-on |
| surf_jump | input | 1 | Current jump is a surf jump |
| cfg_swap_ce | input | 1 | Route the centre error into the tracking path |
| cfg_brake_at_input | input | 1 | Cancel flag masks filter input (1) or output (0) |
| cfg_mirr_mask | input | 1 | Mask filter input while the mirror level is high |
| cfg_hold_surf | input | 1 | Freeze the output during a surf jump |
| cfg_clear_on_servo | input | 1 | Request a state clear on surf-jump exit |
| filt_dout | input | SAMPLE_W | Result from the tracking filter |
| filt_din | output | SAMPLE_W | Sample sent to the tracking filter |
| trk_drive | output | SAMPLE_W | Conditioned tracking output |
| filt_clear | output | 1 | One-clock filter state clear request |

## Verification
On every cycle, the assertions check the following. The cancel flag changes only right after a zero-cross change. Each masking condition forces the matching registered sample to zero. The output stays frozen while a hold is active. The clear request is a single clock wide and only follows a qualified jump exit. Three things can only be shown by the bench's scenarios. The first is the exact edge-to-output latency through the synchronisers. The second is that both zero-cross polarities capture the mirror level. The third is that the frozen value is the one from before the jump and not merely some stable value.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        BRAKE_AT_OUTPUT = 1'b0,
        BRAKE_AT_INPUT  = 1'b1
    } brake_target_e;

    typedef struct packed {
        logic tzc_prev;
        logic cancel;
    } cancel_state_t;

endpackage

// File: rtl/tbc_sync.sv
module tbc_sync #(
    parameter int N      = 2,
    parameter int STAGES = tbc_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [STAGES-1:0][N-1:0] chain_d, chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign chain_d[s] = din;
            end else begin : g_next
                assign chain_d[s] = chain_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/tbc_cancel.sv
module tbc_cancel
    import tbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mirr_s,
    input  logic tzc_s,
    output logic cancel,
    output logic tzc_edge
);
    cancel_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.tzc_prev = tzc_s;
        tzc_edge      = tzc_s ^ st_q.tzc_prev;
        if (tzc_edge) st_d.cancel = mirr_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cancel = st_q.cancel;

    AST_CANCEL_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !tzc_edge |=> $stable(cancel)); // R1
    AST_CANCEL_TAKES_MIRR: assert property (@(posedge clk) disable iff (!rst_n)
        tzc_edge |=> cancel == $past(mirr_s)); // R1
endmodule

// File: rtl/tbc_in_path.sv
module tbc_in_path
    import tbc_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] te_in,
    input  logic [SAMPLE_W-1:0] ce_in,
    input  logic                swap_ce,
    input  brake_target_e       brake_tgt,
    input  logic                cancel,
    input  logic                mirr_mask,
    input  logic                mirr_s,
    output logic [SAMPLE_W-1:0] filt_din
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] sample;
    } in_state_t;

    in_state_t st_d, st_q;
    logic      brake_hit, mirr_hit;

    always_comb begin
        brake_hit = (brake_tgt == BRAKE_AT_INPUT) && cancel;
        mirr_hit  = mirr_mask && mirr_s;
        st_d      = st_q;
        if (brake_hit || mirr_hit) st_d.sample = '0;
        else if (swap_ce)          st_d.sample = ce_in;
        else                       st_d.sample = te_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_din = st_q.sample;

    AST_IN_BRAKE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (brake_tgt == BRAKE_AT_INPUT && cancel) |=> filt_din == '0); // R3
    AST_IN_MIRR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mirr_mask && mirr_s) |=> filt_din == '0); // R4
    AST_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!(brake_tgt == BRAKE_AT_INPUT && cancel) && !(mirr_mask && mirr_s))
        |=> filt_din == ($past(swap_ce) ? $past(ce_in) : $past(te_in))); // R7
endmodule

// File: rtl/tbc_out_path.sv
module tbc_out_path
    import tbc_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] filt_dout,
    input  brake_target_e       brake_tgt,
    input  logic                cancel,
    input  logic                hold_en,
    input  logic                clear_en,
    input  logic                surf_jump,
    input  logic                jump_active,
    output logic [SAMPLE_W-1:0] trk_drive,
    output logic                filt_clear
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] drive;
        logic                jump_prev;
        logic                clr;
    } out_state_t;

    out_state_t st_d, st_q;
    logic       hold_act, mask_out, jump_exit;

    always_comb begin
        hold_act  = hold_en && surf_jump && jump_active;
        mask_out  = (brake_tgt == BRAKE_AT_OUTPUT) && cancel;
        jump_exit = st_q.jump_prev && !jump_active;
        st_d           = st_q;
        st_d.jump_prev = jump_active;
        st_d.clr       = clear_en && surf_jump && jump_exit;
        if (hold_act)      st_d.drive = st_q.drive;
        else if (mask_out) st_d.drive = '0;
        else               st_d.drive = filt_dout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trk_drive  = st_q.drive;
    assign filt_clear = st_q.clr;

    AST_OUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!(hold_en && surf_jump && jump_active) && brake_tgt == BRAKE_AT_OUTPUT && cancel)
        |=> trk_drive == '0); // R2
    AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(hold_en && surf_jump && jump_active) && !(brake_tgt == BRAKE_AT_OUTPUT && cancel))
        |=> trk_drive == $past(filt_dout)); // R2
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_en && surf_jump && jump_active) |=> $stable(trk_drive)); // R5
    AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        filt_clear |=> !filt_clear); // R6
    AST_CLEAR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filt_clear) |-> $past(clear_en && surf_jump && !jump_active)); // R6
endmodule

// File: rtl/trk_brake_ctrl.sv
module trk_brake_ctrl
    import tbc_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] te_in,
    input  logic [SAMPLE_W-1:0] ce_in,
    input  logic                mirr_in,
    input  logic                tzc_in,
    input  logic                jump_active,
    input  logic                surf_jump,
    input  logic                cfg_swap_ce,
    input  logic                cfg_brake_at_input,
    input  logic                cfg_mirr_mask,
    input  logic                cfg_hold_surf,
    input  logic                cfg_clear_on_servo,
    input  logic [SAMPLE_W-1:0] filt_dout,
    output logic [SAMPLE_W-1:0] filt_din,
    output logic [SAMPLE_W-1:0] trk_drive,
    output logic                filt_clear
);
    localparam int N_SYNC = 2;

    logic [N_SYNC-1:0] async_lv, sync_lv;
    logic              mirr_s, tzc_s, cancel, tzc_edge;
    brake_target_e     brake_tgt;

    assign async_lv  = {tzc_in, mirr_in};
    assign mirr_s    = sync_lv[0];
    assign tzc_s     = sync_lv[1];
    assign brake_tgt = brake_target_e'(cfg_brake_at_input);

    tbc_sync #(.N(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (async_lv),
        .dout (sync_lv)
    );

    tbc_cancel u_cancel (
        .clk     (clk),
        .rst_n   (rst_n),
        .mirr_s  (mirr_s),
        .tzc_s   (tzc_s),
        .cancel  (cancel),
        .tzc_edge(tzc_edge)
    );

    tbc_in_path #(.SAMPLE_W(SAMPLE_W)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .te_in    (te_in),
        .ce_in    (ce_in),
        .swap_ce  (cfg_swap_ce),
        .brake_tgt(brake_tgt),
        .cancel   (cancel),
        .mirr_mask(cfg_mirr_mask),
        .mirr_s   (mirr_s),
        .filt_din (filt_din)
    );

    tbc_out_path #(.SAMPLE_W(SAMPLE_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .filt_dout  (filt_dout),
        .brake_tgt  (brake_tgt),
        .cancel     (cancel),
        .hold_en    (cfg_hold_surf),
        .clear_en   (cfg_clear_on_servo),
        .surf_jump  (surf_jump),
        .jump_active(jump_active),
        .trk_drive  (trk_drive),
        .filt_clear (filt_clear)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (filt_clear == 1'b0 || rst_n)); // R8
    AST_EDGE_NEEDS_TZC_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tzc_edge |-> $past(tzc_s) != tzc_s); // R1
endmodule

// File: tb/trk_brake_ctrl_test.sv
`timescale 1ns/1ps
module trk_brake_ctrl_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] te = '0, ce = '0, fo = '0;
    logic         mirr = 1'b0, tzc = 1'b0, jump = 1'b0, surf = 1'b0;
    logic         swap = 1'b0, bsel = 1'b0, mmask = 1'b0, hold = 1'b0, clr = 1'b0;
    logic [W-1:0] filt_din, trk_drive;
    logic         filt_clear;

    int n_run = 0, n_fail = 0;
    logic cancel_m = 1'b0;

    always #10 clk = ~clk;

    trk_brake_ctrl #(.SAMPLE_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .te_in(te), .ce_in(ce),
        .mirr_in(mirr), .tzc_in(tzc), .jump_active(jump), .surf_jump(surf),
        .cfg_swap_ce(swap), .cfg_brake_at_input(bsel), .cfg_mirr_mask(mmask),
        .cfg_hold_surf(hold), .cfg_clear_on_servo(clr), .filt_dout(fo),
        .filt_din(filt_din), .trk_drive(trk_drive), .filt_clear(filt_clear)
    );

    function automatic logic [W-1:0] exp_in(logic [W-1:0] t, logic [W-1:0] c, logic sw,
                                            logic bs, logic cn, logic mm, logic mr);
        if ((bs && cn) || (mm && mr)) return '0;
        return sw ? c : t;
    endfunction

    function automatic logic [W-1:0] exp_out(logic [W-1:0] f, logic bs, logic cn);
        return (!bs && cn) ? '0 : f;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic make_cancel(logic v);
        mirr = v;
        repeat (3) tick();
        tzc = ~tzc;
        repeat (4) tick();
        cancel_m = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) tick();
        // R8: reset state
        chk("R8 din", filt_din, '0);
        chk("R8 drive", trk_drive, '0);
        chk("R8 clear", {15'd0, filt_clear}, '0);
        rst_n = 1'b1;
        tick();
        chk("R8 din after", filt_din, '0);
        chk("R8 drive after", trk_drive, '0);

        // R1: cancel timing, rising zero-cross edge
        fo = 16'h1234;
        mirr = 1'b1;
        repeat (3) tick();
        chk("R1 no edge yet", trk_drive, 16'h1234);
        tzc = 1'b1;
        repeat (3) tick();
        chk("R1 before update", trk_drive, 16'h1234);
        tick();
        chk("R1 rising capture", trk_drive, '0);
        // R1: mirror change without edge keeps flag
        mirr = 1'b0;
        repeat (5) tick();
        chk("R1 no edge hold", trk_drive, '0);
        // R1: falling edge captures low mirror
        tzc = 1'b0;
        repeat (4) tick();
        chk("R1 falling capture", trk_drive, 16'h1234);
        cancel_m = 1'b0;

        // R3: cancel masks input, output free
        bsel = 1'b1;
        make_cancel(1'b1);
        te = 16'h5555; fo = 16'h7777;
        tick();
        chk("R3 input masked", filt_din, '0);
        chk("R3 output free", trk_drive, 16'h7777);

        // R4: mirror mask independent of cancel
        bsel = 1'b0;
        make_cancel(1'b0);
        mirr = 1'b1; mmask = 1'b1;
        repeat (3) tick();
        chk("R4 mirror mask", filt_din, '0);
        mmask = 1'b0;
        tick();
        chk("R4 mask off", filt_din, 16'h5555);
        mirr = 1'b0;
        repeat (3) tick();

        // Random mix: R2, R3, R4, R7
        for (int blk = 0; blk < 8; blk++) begin
            swap  = $urandom_range(0, 1);
            bsel  = $urandom_range(0, 1);
            mmask = $urandom_range(0, 1);
            make_cancel(1'($urandom_range(0, 1)));
            mirr = $urandom_range(0, 1);
            repeat (3) tick();
            for (int i = 0; i < 20; i++) begin
                te = W'($urandom); ce = W'($urandom); fo = W'($urandom);
                tick();
                chk("R7 R3 R4 input path", filt_din, exp_in(te, ce, swap, bsel, cancel_m, mmask, mirr));
                chk("R2 output path", trk_drive, exp_out(fo, bsel, cancel_m));
            end
        end

        // R5: hold during surf jump
        swap = 1'b0; bsel = 1'b0; mmask = 1'b0;
        make_cancel(1'b0);
        hold = 1'b1;
        fo = 16'hA5A5;
        tick();
        chk("R5 pre-hold", trk_drive, 16'hA5A5);
        jump = 1'b1; surf = 1'b1;
        for (int i = 0; i < 6; i++) begin
            fo = W'($urandom);
            tick();
            chk("R5 held", trk_drive, 16'hA5A5);
        end
        jump = 1'b0; surf = 1'b0; fo = 16'h0F0F;
        tick();
        chk("R5 release", trk_drive, 16'h0F0F);
        hold = 1'b0; jump = 1'b1; surf = 1'b1; fo = 16'h3C3C;
        tick();
        chk("R5 hold off follows", trk_drive, 16'h3C3C);

        // R6: clear pulse on qualified jump exit
        clr = 1'b1;
        tick();
        jump = 1'b0;
        tick();
        chk("R6 pulse high", {15'd0, filt_clear}, 16'd1);
        tick();
        chk("R6 pulse one clock", {15'd0, filt_clear}, '0);
        jump = 1'b1; surf = 1'b0;
        tick();
        chk("R6 no pulse on entry", {15'd0, filt_clear}, '0);
        jump = 1'b0;
        tick(); tick();
        chk("R6 no pulse without surf", {15'd0, filt_clear}, '0);
        clr = 1'b0; surf = 1'b1; jump = 1'b1;
        tick();
        jump = 1'b0;
        tick(); tick();
        chk("R6 no pulse without enable", {15'd0, filt_clear}, '0);

        // R7: directed swap
        surf = 1'b0; swap = 1'b1; te = 16'h1111; ce = 16'h2222;
        tick();
        chk("R7 centre selected", filt_din, 16'h2222);
        swap = 1'b0;
        tick();
        chk("R7 tracking selected", filt_din, 16'h1111);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule